// File: doc/BRIEF.md
# Interrupt Arbiter with Promotable Source

This block picks one winner per cycle from twenty maskable interrupt request lines. The requests arrive already qualified by their local enables. Without any promotion, a fixed order decides the winner. A 5-bit select register can lift any single source above all the others. The winner is reported as a 5-bit source code with a valid flag. The path from the request lines to the winner is purely combinational. Only the select register is clocked.

The select register can be written only while the CPU's global interrupt-mask bit is set. Writes made while the mask is clear are dropped. Codes that name no source fall back to promoting the external IRQ line. While the mask is set, no winner is reported, whatever requests are pending.

Top module: `intarb_top`

## Requirements
- R1: After reset, `psel_rdata` reads 00110 (the external IRQ is promoted).
- R2: A write (`psel_we`=1) made while `imask`=0 leaves the stored select value unchanged, and `psel_rdata` keeps its old value on the following cycles.
- R3: A write made while `imask`=1 stores `psel_wdata` at that clock edge. From the next cycle, `psel_rdata` returns the stored value.
- R4: Request bit i (0..19) belongs to source code 6+i. Bit 0 is the external IRQ, bit 1 the real-time interrupt, bits 2..4 timer-1 captures 1..3, bits 5..8 timer-1 compares 1..4, bit 9 timer-1 compare 5/capture 4, bit 10 timer-1 overflow, bit 11 pulse-accumulator overflow, bit 12 pulse-accumulator edge, bit 13 SPI, bit 14 SCI, bits 15..17 the three timer-2 sources, and bits 18..19 the two timer-3 sources.
- R5: When the stored select code is in 6..25 and the matching request bit is set, that source wins, even if lower-numbered bits are also requesting.
- R6: Select codes 0..5 and 26..31 are reserved. Each behaves exactly like code 00110, which promotes the external IRQ.
- R7: If the promoted source is not requesting, the lowest-numbered requesting bit wins.
- R8: While `imask`=1, `win_valid` is 0 and `win_code` is 0, whatever the requests are.
- R9: With `imask`=0 and no request bit set, `win_valid` is 0 and `win_code` is 0.
- R10: The winner follows the request lines and the stored select value in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select register |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 20 | Qualified request lines, bit i is source code 6+i |
| imask | input | 1 | Global interrupt-mask bit (1 = interrupts masked) |
| psel_wdata | input | 5 | Write data for the select register |
| psel_we | input | 1 | Write strobe for the select register |
| psel_rdata | output | 5 | Stored select value |
| win_code | output | 5 | Code of the granted source, 0 when none |
| win_valid | output | 1 | A source is granted |

## Verification
The bench makes writes with the mask clear, because a design that ignored the guard would change the stored code and shift the priority. It steps through every reserved code while lower-priority sources also request. A design that decoded those codes as a real source would promote a wrong line, or stop promoting the IRQ. It also sets the promoted source's request together with the external IRQ. This exposes a design that let the fixed order override the promotion. Finally, it checks that requests pending under the mask produce no valid winner.

// File: rtl/intarb_pkg.sv
package intarb_pkg;
   localparam int unsigned SRC_N     = 20;
   localparam int unsigned CODE_W    = 5;
   localparam int unsigned CODE_BASE = 6;
   localparam int unsigned SEL_RST   = 6;
endpackage

// File: rtl/intarb_selreg.sv
module intarb_selreg #(
   parameter int unsigned CODE_W  = 5,
   parameter int unsigned SEL_RST = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              imask,
   input  logic              we,
   input  logic [CODE_W-1:0] wdata,
   output logic [CODE_W-1:0] sel_q
);
   initial begin
      if (SEL_RST >= (1 << CODE_W)) $error("SEL_RST does not fit CODE_W");
   end

   logic accept;
   assign accept = we & imask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= CODE_W'(SEL_RST);
      else if (accept)
         sel_q <= wdata;
   end
endmodule

// File: rtl/intarb_promo_dec.sv
module intarb_promo_dec #(
   parameter int unsigned SRC_N     = 20,
   parameter int unsigned CODE_W    = 5,
   parameter int unsigned CODE_BASE = 6
) (
   input  logic [CODE_W-1:0] sel,
   output logic [SRC_N-1:0]  promo
);
   initial begin
      if (CODE_BASE + SRC_N > (1 << CODE_W)) $error("source codes exceed CODE_W");
      if (SRC_N < 2) $error("SRC_N must be at least 2");
   end

   logic [SRC_N-1:0] hit;
   logic             reserved;

   for (genvar i = 0; i < SRC_N; i++) begin : g_hit
      assign hit[i] = (sel == CODE_W'(CODE_BASE + i));
   end

   assign reserved = ~|hit;
   // reserved codes fall back to the source at bit 0
   assign promo = {hit[SRC_N-1:1], hit[0] | reserved};
endmodule

// File: rtl/intarb_prienc.sv
module intarb_prienc #(
   parameter int unsigned N  = 20,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign found = |vec;
endmodule

// File: rtl/intarb_top.sv
module intarb_top #(
   parameter int unsigned SRC_N     = intarb_pkg::SRC_N,
   parameter int unsigned CODE_W    = intarb_pkg::CODE_W,
   parameter int unsigned CODE_BASE = intarb_pkg::CODE_BASE,
   parameter int unsigned SEL_RST   = intarb_pkg::SEL_RST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_N-1:0]  irq_req,
   input  logic              imask,
   input  logic [CODE_W-1:0] psel_wdata,
   input  logic              psel_we,
   output logic [CODE_W-1:0] psel_rdata,
   output logic [CODE_W-1:0] win_code,
   output logic              win_valid
);
   localparam int unsigned IW = $clog2(SRC_N);

   initial begin
      if (IW > CODE_W) $error("index wider than code");
   end

   logic [CODE_W-1:0] sel_q;
   logic [SRC_N-1:0]  promo;
   logic [SRC_N-1:0]  promo_req;
   logic              p_found, f_found;
   logic [IW-1:0]     p_idx, f_idx, g_idx;

   intarb_selreg #(.CODE_W(CODE_W), .SEL_RST(SEL_RST)) u_sel (
      .clk(clk), .rst_n(rst_n), .imask(imask), .we(psel_we),
      .wdata(psel_wdata), .sel_q(sel_q)
   );

   intarb_promo_dec #(.SRC_N(SRC_N), .CODE_W(CODE_W), .CODE_BASE(CODE_BASE)) u_dec (
      .sel(sel_q), .promo(promo)
   );

   assign promo_req = promo & irq_req;

   intarb_prienc #(.N(SRC_N), .IW(IW)) u_penc (
      .vec(promo_req), .found(p_found), .idx(p_idx)
   );

   intarb_prienc #(.N(SRC_N), .IW(IW)) u_fenc (
      .vec(irq_req), .found(f_found), .idx(f_idx)
   );

   assign g_idx      = p_found ? p_idx : f_idx;
   assign win_valid  = f_found & ~imask;
   assign win_code   = win_valid ? (CODE_W'(g_idx) + CODE_W'(CODE_BASE)) : '0;
   assign psel_rdata = sel_q;
endmodule

// File: rtl/intarb_chk.sv
module intarb_chk #(
   parameter int unsigned SRC_N     = 20,
   parameter int unsigned CODE_W    = 5,
   parameter int unsigned CODE_BASE = 6,
   parameter int unsigned SEL_RST   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SRC_N-1:0]  irq_req,
   input logic              imask,
   input logic [CODE_W-1:0] psel_wdata,
   input logic              psel_we,
   input logic [CODE_W-1:0] psel_rdata,
   input logic [CODE_W-1:0] win_code,
   input logic              win_valid
);
   logic [CODE_W-1:0] off;
   logic              won_req;
   logic [CODE_W-1:0] psel_off;
   logic              promo_pending;

   assign off      = win_code - CODE_W'(CODE_BASE);
   assign won_req  = (off < CODE_W'(SRC_N)) ? irq_req[off] : 1'b0;
   assign psel_off = psel_rdata - CODE_W'(CODE_BASE);
   assign promo_pending = (psel_off < CODE_W'(SRC_N)) ? irq_req[psel_off] : 1'b0;

   // R2
   a_r2_masked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (psel_we && !imask) |=> $stable(psel_rdata));
   // R3
   a_r3_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (psel_we && imask) |=> (psel_rdata == $past(psel_wdata)));
   // R5
   a_r5_promoted_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (!imask && promo_pending) |-> (win_valid && win_code == psel_rdata));
   // R7
   a_r7_winner_requesting: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> won_req);
   // R8
   a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      imask |-> (!win_valid && win_code == '0));
   // R9
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!imask && irq_req == '0) |-> (!win_valid && win_code == '0));
endmodule

bind intarb_top intarb_chk #(
   .SRC_N(SRC_N), .CODE_W(CODE_W), .CODE_BASE(CODE_BASE), .SEL_RST(SEL_RST)
) u_chk (.*);

// File: tb/sim_intarb_top.sv
`timescale 1ns/1ps
module sim_intarb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] irq_req = '0;
   logic        imask = 1'b0;
   logic [4:0]  psel_wdata = '0;
   logic        psel_we = 1'b0;
   logic [4:0]  psel_rdata, win_code;
   logic        win_valid;

   int checks = 0;
   int errors = 0;
   logic [4:0] m_sel;

   always #10 clk = ~clk;

   intarb_top u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .imask(imask),
      .psel_wdata(psel_wdata), .psel_we(psel_we), .psel_rdata(psel_rdata),
      .win_code(win_code), .win_valid(win_valid)
   );

   function automatic logic [5:0] exp_win(logic [19:0] r, logic m, logic [4:0] s);
      int p;
      p = (s >= 6 && s <= 25) ? int'(s) - 6 : 0;
      if (m || r == '0) return 6'd0;
      if (r[p]) return {1'b1, 5'(p + 6)};
      for (int i = 0; i < 20; i++)
         if (r[i]) return {1'b1, 5'(i + 6)};
      return 6'd0;
   endfunction

   task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one cycle: drive, check winner and readback, clock, update model
   task automatic step(string tag, logic [19:0] r, logic m, logic we, logic [4:0] wd);
      @(negedge clk);
      irq_req = r; imask = m; psel_we = we; psel_wdata = wd;
      #2;
      chk({tag, " winner (R10)"}, {win_valid, win_code}, exp_win(r, m, m_sel));
      chk({tag, " readback"}, {1'b0, psel_rdata}, {1'b0, m_sel});
      @(posedge clk);
      if (we && m) m_sel = wd;
      #1;
      psel_we = 1'b0;
   endtask

   initial begin
      int seed;
      logic [19:0] r;
      m_sel = 5'd6;
      seed = 32'h1234_abcd;
      void'($urandom(seed));
      #35;
      chk("R1 reset select", {1'b0, psel_rdata}, 6'd6);
      rst_n = 1'b1;
      step("R9 idle", '0, 1'b0, 1'b0, '0);
      step("R8 masked", 20'hFFFFF, 1'b1, 1'b0, '0);
      step("R7 fixed order", 20'h00110, 1'b0, 1'b0, '0);
      // R2: write with mask clear must be dropped
      step("R2 unmasked write", 20'h80001, 1'b0, 1'b1, 5'd25);
      step("R2 after write", 20'h80001, 1'b0, 1'b0, '0);
      // R3 + R5: promote each real source with IRQ also pending
      for (int c = 6; c <= 25; c++) begin
         step("R3 masked write", '0, 1'b1, 1'b1, 5'(c));
         step("R5 promoted vs IRQ (R4)", 20'h00001 | (20'h1 << (c - 6)), 1'b0, 1'b0, '0);
         step("R7 promoted idle", 20'hFFFFF & ~(20'h1 << (c - 6)), 1'b0, 1'b0, '0);
      end
      // R6: reserved codes act as IRQ promotion
      for (int c = 0; c < 32; c++) begin
         if (c >= 6 && c <= 25) continue;
         step("R6 reserved write", '0, 1'b1, 1'b1, 5'(c));
         step("R6 reserved code", 20'hC0002, 1'b0, 1'b0, '0);
         step("R6 reserved IRQ", 20'hC0003, 1'b0, 1'b0, '0);
      end
      // random mix
      for (int k = 0; k < 3000; k++) begin
         r = 20'($urandom);
         if ($urandom_range(3) == 0) r = r & 20'($urandom);
         if ($urandom_range(7) == 0) r = '0;
         step("R7 random", r, 1'($urandom_range(1)), 1'($urandom_range(1)), 5'($urandom));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule